// File: doc/BRIEF.md
# DMA Completion Status Queue and MSI Request Generator

This block sits beside one data mover in a DMA engine. Each time the mover finishes a descriptor it hands over a completion status word. The block stores these words in a first-in, first-out queue, and a host reads them back, one per read, through a simple memory-mapped port. The same port gives access to a 512-bit interrupt control register. That register holds an enable, a queue-select bit, a 16-bit message data value and a 64-bit target address for a message-signalled interrupt.

When an accepted completion has its interrupt-request bit set and interrupts are enabled, the block counts one pending interrupt. A small state machine turns pending interrupts into requests on a valid/ready output. Each request carries the configured address, the data and a normal/priority select, and goes to an external packet generator. The state machine has two states. In IDLE it waits, and the transition IDLE to ISSUE (take) fires when the pending count is non-zero; this latches the control fields and decrements the count. In ISSUE it holds the request valid, and the transition ISSUE to IDLE (done) fires when the downstream ready is seen. If the status queue or the pending counter is full, the block pushes back on the data mover instead of losing anything.

Top module: `dma_cpl_msi`

## Requirements
- R1: A status word is accepted when `stat_valid` and `stat_ready` are both high at a clock edge. Host reads with `csr_sel`=0 return accepted words oldest first, one word per read. Each word appears in `csr_rdata[30:0]`, with bit 31 and bits 511:32 at zero.
- R2: A status read while the queue is empty returns 0x8000_0000 in bits 31:0 and zero in all other bits, and it removes nothing from the queue.
- R3: When the status queue holds `Q_DEPTH` words, `stat_ready` is low. No word offered while it is low is stored or lost.
- R4: The interrupt control register (`csr_sel`=1) keeps only these bits: enable at 511, priority at 510, message data at 95:80, address at 63:0. A read returns the stored fields with every other bit at zero.
- R5: A write with `csr_sel`=0 has no effect on the status queue or its contents.
- R6: After reset the control register reads as zero (enable clear), the status queue is empty, `stat_ready` is high and `msi_valid` is low.
- R7: An interrupt request is generated for an accepted status word only when bit `IRQ_BIT` (default 24) of that word is set and the enable bit is set at that moment. Otherwise no request is generated.
- R8: Each request presents the control register's address on `msi_addr` and its message data on `msi_data`. It drives `msi_prio` with the priority bit: 1 selects the priority outbound queue and 0 the normal one.
- R9: While `msi_valid` is high and `msi_ready` low, the request and its fields stay unchanged. Further interrupt requests are counted and delivered in order, and `stat_ready` goes low once `PEND_MAX` requests are waiting behind the one on the output.
- R10: `csr_rvalid` is high exactly in the cycle after a cycle with `csr_rd` high, and `csr_rdata` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_valid | input | 1 | Completion status word offered by the data mover |
| stat_ready | output | 1 | Block can accept a status word |
| stat_word | input | STAT_W | Completion status word; bit IRQ_BIT requests an interrupt |
| csr_sel | input | 1 | Register select: 0 status queue, 1 interrupt control |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 512 | Register write data |
| csr_rd | input | 1 | Register read strobe |
| csr_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| csr_rdata | output | 512 | Read data |
| msi_valid | output | 1 | Interrupt request valid |
| msi_ready | input | 1 | Packet generator accepts the request |
| msi_addr | output | 64 | Interrupt message target address |
| msi_data | output | 16 | Interrupt message data |
| msi_prio | output | 1 | 1 selects the priority outbound queue, 0 the normal one |

## Verification
The bench builds the block with `Q_DEPTH`=4 and `PEND_MAX`=2, so both back-pressure limits can be reached in a few pushes. The queue fills after four words. With the output stalled, the pending counter saturates after three interrupting completions, while the queue still has room, and this separates the two causes of a low `stat_ready`. The default `STAT_W`=31 and `IRQ_BIT`=24 are kept, so the empty marker and the interrupt bit sit at their stated positions.

// File: rtl/dma_cpl_msi_pkg.sv
package dma_cpl_msi_pkg;
    localparam int REG_W         = 512;
    localparam int ADDR_W        = 64;
    localparam int MDATA_W       = 16;
    localparam int CTRL_EN_BIT   = 511;
    localparam int CTRL_PRIO_BIT = 510;
    localparam int CTRL_DATA_LSB = 80;
    localparam int CTRL_ADDR_LSB = 0;
    localparam logic [31:0] EMPTY_MARK = 32'h8000_0000;

    typedef enum logic [0:0] {
        MSI_IDLE  = 1'b0,
        MSI_ISSUE = 1'b1
    } msi_state_e;

    typedef struct packed {
        logic               prio;
        logic [MDATA_W-1:0] data;
        logic [ADDR_W-1:0]  addr;
    } msi_req_t;
endpackage

// File: rtl/cplq_fifo.sv
module cplq_fifo #(
    parameter int W     = 31,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    logic do_push, do_pop;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import dma_cpl_msi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic             en,
    output msi_req_t         fields,
    output logic [REG_W-1:0] image
);
    logic               en_q, prio_q;
    logic [MDATA_W-1:0] data_q;
    logic [ADDR_W-1:0]  addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            prio_q <= 1'b0;
            data_q <= '0;
            addr_q <= '0;
        end else if (wr) begin
            en_q   <= wdata[CTRL_EN_BIT];
            prio_q <= wdata[CTRL_PRIO_BIT];
            data_q <= wdata[CTRL_DATA_LSB +: MDATA_W];
            addr_q <= wdata[CTRL_ADDR_LSB +: ADDR_W];
        end
    end

    assign en          = en_q;
    assign fields.prio = prio_q;
    assign fields.data = data_q;
    assign fields.addr = addr_q;

    always_comb begin
        image                               = '0;
        image[CTRL_EN_BIT]                  = en_q;
        image[CTRL_PRIO_BIT]                = prio_q;
        image[CTRL_DATA_LSB +: MDATA_W]     = data_q;
        image[CTRL_ADDR_LSB +: ADDR_W]      = addr_q;
    end
endmodule

// File: rtl/msi_issue_fsm.sv
module msi_issue_fsm
    import dma_cpl_msi_pkg::*;
#(
    parameter int PEND_MAX = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_inc,
    input  msi_req_t cfg,
    output logic     pend_full,
    output logic     msi_valid,
    input  logic     msi_ready,
    output msi_req_t msi_out
);
    localparam int PW = $clog2(PEND_MAX + 1);

    msi_state_e    state_q, state_d;
    logic [PW-1:0] pend_q;
    logic          take;
    msi_req_t      hold_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MSI_IDLE:  if (pend_q != '0) state_d = MSI_ISSUE;  // take
            MSI_ISSUE: if (msi_ready)    state_d = MSI_IDLE;   // done
            default:   state_d = MSI_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MSI_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        msi_valid = 1'b0;
        take      = 1'b0;
        unique case (state_q)
            MSI_IDLE:  take      = (pend_q != '0);
            MSI_ISSUE: msi_valid = 1'b1;
            default:   msi_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            hold_q <= '0;
        end else begin
            unique case ({req_inc, take})
                2'b10:   pend_q <= pend_q + 1'b1;
                2'b01:   pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
            if (take) begin
                hold_q <= cfg;
            end
        end
    end

    assign pend_full = (pend_q == PW'(PEND_MAX));
    assign msi_out   = hold_q;
endmodule

// File: rtl/dma_cpl_msi.sv
module dma_cpl_msi
    import dma_cpl_msi_pkg::*;
#(
    parameter int Q_DEPTH  = 16,
    parameter int PEND_MAX = 4,
    parameter int STAT_W   = 31,
    parameter int IRQ_BIT  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_valid,
    output logic              stat_ready,
    input  logic [STAT_W-1:0] stat_word,
    input  logic              csr_sel,
    input  logic              csr_wr,
    input  logic [511:0]      csr_wdata,
    input  logic              csr_rd,
    output logic              csr_rvalid,
    output logic [511:0]      csr_rdata,
    output logic              msi_valid,
    input  logic              msi_ready,
    output logic [63:0]       msi_addr,
    output logic [15:0]       msi_data,
    output logic              msi_prio
);
    localparam int PAD_W = 32 - STAT_W;

    logic              q_full, q_empty, q_push, q_pop;
    logic [STAT_W-1:0] q_rdata;
    logic              pend_full, irq_en, irq_inc;
    msi_req_t          cfg, req;
    logic [REG_W-1:0]  ctrl_image;
    logic [31:0]       stat_low;

    assign stat_ready = !q_full && !pend_full;
    assign q_push     = stat_valid && stat_ready;
    assign q_pop      = csr_rd && !csr_sel && !q_empty;
    assign irq_inc    = q_push && stat_word[IRQ_BIT] && irq_en;

    cplq_fifo #(
        .W     (STAT_W),
        .DEPTH (Q_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .wdata (stat_word),
        .pop   (q_pop),
        .rdata (q_rdata),
        .full  (q_full),
        .empty (q_empty)
    );

    irq_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (csr_wr && csr_sel),
        .wdata  (csr_wdata),
        .en     (irq_en),
        .fields (cfg),
        .image  (ctrl_image)
    );

    msi_issue_fsm #(
        .PEND_MAX (PEND_MAX)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_inc   (irq_inc),
        .cfg       (cfg),
        .pend_full (pend_full),
        .msi_valid (msi_valid),
        .msi_ready (msi_ready),
        .msi_out   (req)
    );

    assign msi_addr = req.addr;
    assign msi_data = req.data;
    assign msi_prio = req.prio;

    assign stat_low = q_empty ? EMPTY_MARK : {{PAD_W{1'b0}}, q_rdata};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_rvalid <= 1'b0;
            csr_rdata  <= '0;
        end else begin
            csr_rvalid <= csr_rd;
            if (csr_rd) begin
                csr_rdata <= csr_sel ? ctrl_image : {{(REG_W - 32){1'b0}}, stat_low};
            end
        end
    end
endmodule

// File: rtl/dma_cpl_msi_chk.sv
module dma_cpl_msi_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         csr_sel,
    input logic         csr_rd,
    input logic         csr_rvalid,
    input logic [511:0] csr_rdata,
    input logic         msi_valid,
    input logic         msi_ready,
    input logic [63:0]  msi_addr,
    input logic [15:0]  msi_data,
    input logic         msi_prio
);
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rd |=> csr_rvalid);  // R10

    AST_NO_STRAY_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_rd |=> !csr_rvalid);  // R10

    AST_MSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid && !msi_ready) |=> (msi_valid && $stable(msi_addr)
                                       && $stable(msi_data) && $stable(msi_prio)));  // R9

    AST_EMPTY_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rvalid && $past(!csr_sel) && csr_rdata[31]) |-> (csr_rdata[30:0] == '0));  // R2

    AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rvalid && $past(!csr_sel)) |-> (csr_rdata[511:32] == '0));  // R1

    AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rvalid && $past(csr_sel)) |-> (csr_rdata[509:96] == '0 && csr_rdata[79:64] == '0));  // R4
endmodule

bind dma_cpl_msi dma_cpl_msi_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_sel    (csr_sel),
    .csr_rd     (csr_rd),
    .csr_rvalid (csr_rvalid),
    .csr_rdata  (csr_rdata),
    .msi_valid  (msi_valid),
    .msi_ready  (msi_ready),
    .msi_addr   (msi_addr),
    .msi_data   (msi_data),
    .msi_prio   (msi_prio)
);

// File: tb/dma_cpl_msi_test.sv
`timescale 1ns/1ps
module dma_cpl_msi_test;
    localparam int QD = 4;
    localparam int PM = 2;
    localparam int SW = 31;
    localparam int IB = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stat_valid = 1'b0;
    logic          stat_ready;
    logic [SW-1:0] stat_word = '0;
    logic          csr_sel = 1'b0;
    logic          csr_wr = 1'b0;
    logic [511:0]  csr_wdata = '0;
    logic          csr_rd = 1'b0;
    logic          csr_rvalid;
    logic [511:0]  csr_rdata;
    logic          msi_valid;
    logic          msi_ready = 1'b1;
    logic [63:0]   msi_addr;
    logic [15:0]   msi_data;
    logic          msi_prio;

    always #2.5 clk = ~clk;

    dma_cpl_msi #(.Q_DEPTH(QD), .PEND_MAX(PM), .STAT_W(SW), .IRQ_BIT(IB)) uut (
        .clk(clk), .rst_n(rst_n),
        .stat_valid(stat_valid), .stat_ready(stat_ready), .stat_word(stat_word),
        .csr_sel(csr_sel), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rd(csr_rd), .csr_rvalid(csr_rvalid), .csr_rdata(csr_rdata),
        .msi_valid(msi_valid), .msi_ready(msi_ready),
        .msi_addr(msi_addr), .msi_data(msi_data), .msi_prio(msi_prio)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [511:0]  rd_exp[$];
    string         rd_tag[$];
    logic [80:0]   msi_exp[$];
    logic [SW-1:0] stat_model[$];
    logic          en_model = 1'b0;
    logic          prio_model = 1'b0;
    logic [15:0]   data_model = '0;
    logic [63:0]   addr_model = '0;

    task automatic check(input bit ok, input string tag,
                         input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // monitor: compares produced results against scoreboard queues
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && csr_rvalid) begin
                if (rd_exp.size() == 0) begin
                    check(1'b0, "R10 unexpected read data", csr_rdata, '0);
                end else begin
                    logic [511:0] e;
                    string t;
                    e = rd_exp.pop_front();
                    t = rd_tag.pop_front();
                    check(csr_rdata === e, t, csr_rdata, e);
                end
            end
            if (rst_n && msi_valid && msi_ready) begin
                logic [80:0] a;
                a = {msi_prio, msi_data, msi_addr};
                if (msi_exp.size() == 0) begin
                    check(1'b0, "R7 unexpected interrupt request", a, '0);
                end else begin
                    logic [80:0] e;
                    e = msi_exp.pop_front();
                    check(a === e, "R8 interrupt request fields", a, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", '0, '0);
        finish_run();
    end

    task automatic csr_write(input logic sel, input logic [511:0] d);
        @(negedge clk);
        csr_sel = sel; csr_wr = 1'b1; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
        if (sel) begin
            en_model   = d[511];
            prio_model = d[510];
            data_model = d[95:80];
            addr_model = d[63:0];
        end
    endtask

    task automatic csr_read(input logic sel, input logic [511:0] e, input string tag);
        @(negedge clk);
        csr_sel = sel; csr_rd = 1'b1;
        rd_exp.push_back(e);
        rd_tag.push_back(tag);
        @(negedge clk);
        csr_rd = 1'b0;
    endtask

    // read of the status queue, expected value taken from the bench model
    task automatic stat_read(input string tag);
        logic [511:0] e;
        if (stat_model.size() == 0) e = 512'h8000_0000;
        else e = 512'(stat_model.pop_front());
        csr_read(1'b0, e, tag);
    endtask

    task automatic stat_push(input logic [SW-1:0] w);
        @(negedge clk);
        stat_valid = 1'b1; stat_word = w;
        while (!stat_ready) @(negedge clk);
        @(posedge clk);
        stat_model.push_back(w);
        if (w[IB] && en_model) msi_exp.push_back({prio_model, data_model, addr_model});
        @(negedge clk);
        stat_valid = 1'b0;
    endtask

    function automatic logic [511:0] ctrl_word(input logic en, input logic pr,
                                              input logic [15:0] d, input logic [63:0] a);
        logic [511:0] v;
        v = '0; v[511] = en; v[510] = pr; v[95:80] = d; v[63:0] = a;
        return v;
    endfunction

    initial begin
        logic [511:0] mask;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6 reset state
        check(stat_ready === 1'b1, "R6 stat_ready after reset", 512'(stat_ready), 512'd1);
        check(msi_valid === 1'b0, "R6 msi_valid after reset", 512'(msi_valid), 512'd0);
        csr_read(1'b1, '0, "R6 control reads zero after reset");
        stat_read("R2 empty queue marker after reset");

        // R4 reserved bits
        csr_write(1'b1, '1);
        mask = ctrl_word(1'b1, 1'b1, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        csr_read(1'b1, mask, "R4 control readback with reserved bits zero");
        csr_write(1'b1, ctrl_word(1'b0, 1'b0, 16'h0000, 64'h0));

        // R5 write to status select ignored
        csr_write(1'b0, 512'h1234_5678);
        stat_read("R5 status write ignored, still empty");

        // R1 R3 with interrupts disabled (R7)
        stat_push(31'h0100_0011);
        stat_push(31'h0000_0022);
        stat_push(31'h0100_0033);
        stat_push(31'h7ABC_DE44);
        @(negedge clk);
        check(stat_ready === 1'b0, "R3 stat_ready low when queue full", 512'(stat_ready), 512'd0);
        check(msi_valid === 1'b0, "R7 no request while disabled", 512'(msi_valid), 512'd0);
        stat_read("R1 oldest word first");
        stat_read("R1 second word");
        stat_read("R1 third word");
        stat_read("R1 fourth word");
        stat_read("R2 marker after draining");
        stat_read("R2 marker again, nothing popped");

        // R7 R8 with interrupts enabled
        csr_write(1'b1, ctrl_word(1'b1, 1'b0, 16'hA5C3, 64'h0000_00FE_E000_1000));
        stat_push(31'h0000_0101);
        repeat (5) @(negedge clk);
        check(msi_valid === 1'b0, "R7 no request without interrupt bit", 512'(msi_valid), 512'd0);
        stat_push(31'h0100_0102);
        repeat (6) @(negedge clk);
        csr_write(1'b1, ctrl_word(1'b1, 1'b1, 16'h0042, 64'h8000_0000_DEAD_0040));
        csr_read(1'b1, ctrl_word(1'b1, 1'b1, 16'h0042, 64'h8000_0000_DEAD_0040),
                 "R4 control fields readback");
        stat_push(31'h01FF_0103);
        repeat (6) @(negedge clk);
        stat_read("R1 drain after interrupt test");
        stat_read("R1 drain after interrupt test");
        stat_read("R1 drain after interrupt test");

        // R9 stall, queueing and pending limit
        msi_ready = 1'b0;
        stat_push(31'h0100_0201);
        stat_push(31'h0100_0202);
        stat_push(31'h0100_0203);
        @(negedge clk);
        check(stat_ready === 1'b0, "R9 stat_ready low at pending limit", 512'(stat_ready), 512'd0);
        check(msi_valid === 1'b1, "R9 request held while stalled", 512'(msi_valid), 512'd1);
        repeat (4) @(negedge clk);
        check(msi_valid === 1'b1, "R9 request still held", 512'(msi_valid), 512'd1);
        msi_ready = 1'b1;
        repeat (12) @(negedge clk);
        check(stat_ready === 1'b1, "R9 stat_ready back after drain", 512'(stat_ready), 512'd1);
        stat_read("R1 drain after stall test");
        stat_read("R1 drain after stall test");
        stat_read("R1 drain after stall test");
        stat_read("R2 marker at end");
        repeat (6) @(negedge clk);
        check(msi_exp.size() == 0, "R9 all requests delivered in order",
              512'(msi_exp.size()), 512'd0);
        check(rd_exp.size() == 0, "R10 every read returned data",
              512'(rd_exp.size()), 512'd0);
        finish_run();
    end
endmodule